// File: doc/BRIEF.md
# Up/Down Event Timer with Selectable Direction Source

This block is a parameterised up/down counter that advances once for every rising edge of an external event input. The event input and the external direction pin are both brought into the system clock domain through a synchroniser chain. A rising-edge detector then turns each event edge into a single-cycle step. The counter compares its value against a programmable period. When a step makes the count equal to that period, it sets a sticky interrupt flag.

Software reaches the block through a write strobe, a 2-bit address and a data word. Address 0 loads the count, address 1 loads the period, address 2 loads the control bits, and a write to address 3 clears the flag. The count direction comes from the control register or from the external direction pin, as a control bit selects. A status output shows the direction that is in effect. Counting is gated by a mode input, a sleep input, and an idle input combined with a stop-in-idle control bit. None of these gates alters the stored count.

Top module: `dirsel_timer`

## Requirements
- R1: After reset the count is 0, the period is all ones, the control bits are 0, the flag is 0, and `dir_up_o` is 0.
- R2: Each rising edge of `ext_clk_i` produces exactly one count step, provided the input stays high and low for at least two clock cycles each. The step lands on the third rising clock edge after the input rises. A falling edge produces no step.
- R3: When control bit 1 (direction source) is 0, control bit 0 selects the direction: 1 counts up and 0 counts down.
- R4: When control bit 1 is 1, the synchronised `dir_pin_i` selects the direction: high counts up and low counts down. `dir_up_o` is 1 exactly when the direction in effect is up.
- R5: Counting up, a step taken while the count equals the period loads 0. Any other up step adds one, modulo 2^CNT_W.
- R6: Counting down, a step taken while the count is 0 loads the period. Any other down step subtracts one.
- R7: A step whose result equals the period sets the flag. The flag stays set until a write to address 3 clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: A write to address 0 loads the count and overrides a step in the same cycle. That step neither changes the count nor sets the flag.
- R9: While `mode_i` is low no step is taken and the count holds. Counting resumes from the held value when `mode_i` returns high.
- R10: While `sleep_i` is high no step is taken and the count holds.
- R11: While `idle_i` is high, the counter keeps stepping if control bit 2 is 0 and halts if it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External event input; each rising edge is one count step |
| dir_pin_i | input | 1 | External direction pin (high = up) |
| mode_i | input | 1 | Timer mode enable; counting only when high |
| sleep_i | input | 1 | Sleep request; halts counting |
| idle_i | input | 1 | Idle request; halts counting when control bit 2 is set |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 count, 1 period, 2 control, 3 flag clear |
| wr_data_i | input | CNT_W | Write data; control uses bits 2:0 |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Sticky period-match flag |
| dir_up_o | output | 1 | Direction currently in effect (1 = up) |

## Verification
Two pairs of events can fall in the same clock cycle. A count-register write can coincide with a count step, and a flag-clear write can coincide with a step that sets the flag. The bench provokes each collision by placing the write strobe exactly on the cycle in which the synchronised edge produces its step, counting the synchroniser and edge-detector registers to find that cycle. The count-write collision passes only if the count holds the written value with no increment and the flag stays clear. The flag collision passes only if the flag ends set and the count has moved onto the period.

// File: rtl/dirsel_timer_pkg.sv
package dirsel_timer_pkg;

   typedef enum logic [1:0] {
      REG_COUNT   = 2'd0,
      REG_PERIOD  = 2'd1,
      REG_CTRL    = 2'd2,
      REG_FLAGCLR = 2'd3
   } reg_addr_e;

   // control word, bit 0 = software direction, bit 1 = direction source,
   // bit 2 = halt while idle
   typedef struct packed {
      logic idle_stop;
      logic dir_src;
      logic dir_sw;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/dst_sync.sv
module dst_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("dst_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d_i;
         else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dst_edge.sv
module dst_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

   // R2: one step per edge, never two in a row
   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/dst_core.sv
module dst_core #(
   parameter int              CNT_W      = 16,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             up_i,
   input  logic             cnt_wr_i,
   input  logic             per_wr_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] count_q, period_q, nxt;
   logic             irq_q, hit;

   always_comb begin
      nxt = count_q;
      hit = 1'b0;
      if (step_i) begin
         if (up_i) nxt = (count_q == period_q) ? '0 : count_q + 1'b1;
         else      nxt = (count_q == '0) ? period_q : count_q - 1'b1;
         hit = (nxt == period_q) && !cnt_wr_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         period_q <= PERIOD_RST;
         irq_q    <= 1'b0;
      end else begin
         count_q <= cnt_wr_i ? wdata_i : nxt;
         if (per_wr_i) period_q <= wdata_i;
         irq_q <= hit | (irq_q & ~clr_i);
      end
   end

   assign count_o = count_q;
   assign irq_o   = irq_q;

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt_wr_i && rst_n) |-> count_q == $past(wdata_i));
   a_r5_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && step_i && up_i && !cnt_wr_i && count_q == period_q) |-> count_q == '0);
   a_r6_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && step_i && !up_i && !cnt_wr_i && count_q == '0) |-> count_q == $past(period_q));
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && irq_q && !clr_i) |-> irq_q);
   a_r9_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!step_i && !cnt_wr_i) |-> count_q == $past(count_q));
endmodule

// File: rtl/dirsel_timer.sv
module dirsel_timer
   import dirsel_timer_pkg::*;
#(
   parameter int              CNT_W      = 16,
   parameter int              SYNC_STG   = 2,
   parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_i,
   input  logic             dir_pin_i,
   input  logic             mode_i,
   input  logic             sleep_i,
   input  logic             idle_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             dir_up_o
);
   localparam int SYNC_W = 2;

   if (CNT_W < CTRL_BITS + 1) begin : g_bad_width
      $error("dirsel_timer: CNT_W too small for control word");
   end

   ctrl_t            ctrl_q;
   logic [SYNC_W-1:0] sync_s;
   logic             ev_s, pin_s, ev_rise, step, up;
   logic             wr_cnt, wr_per, wr_ctl, wr_clr, run;

   assign wr_cnt = wr_en_i && (wr_addr_i == REG_COUNT);
   assign wr_per = wr_en_i && (wr_addr_i == REG_PERIOD);
   assign wr_ctl = wr_en_i && (wr_addr_i == REG_CTRL);
   assign wr_clr = wr_en_i && (wr_addr_i == REG_FLAGCLR);

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_ctl) ctrl_q <= ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
   end

   dst_sync #(.STAGES(SYNC_STG), .WIDTH(SYNC_W)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({dir_pin_i, ext_clk_i}), .q_o(sync_s));
   assign ev_s  = sync_s[0];
   assign pin_s = sync_s[1];

   dst_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl_i(ev_s), .rise_o(ev_rise));

   assign up       = ctrl_q.dir_src ? pin_s : ctrl_q.dir_sw;
   assign dir_up_o = up;

   assign run  = mode_i && !sleep_i && !(idle_i && ctrl_q.idle_stop);
   assign step = ev_rise && run;

   dst_core #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_core (
      .clk(clk), .rst_n(rst_n), .step_i(step), .up_i(up),
      .cnt_wr_i(wr_cnt), .per_wr_i(wr_per), .clr_i(wr_clr),
      .wdata_i(wr_data_i), .count_o(count_o), .irq_o(irq_o));

   a_r10_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sleep_i && !wr_cnt) |-> count_o == $past(count_o));
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(idle_i && ctrl_q.idle_stop && !wr_cnt) |-> count_o == $past(count_o));
   a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mode_i && !wr_cnt) |-> count_o == $past(count_o));
endmodule

// File: tb/dirsel_timer_tb_top.sv
module dirsel_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk_i = 1'b0, dir_pin_i = 1'b0, mode_i = 1'b0;
   logic        sleep_i = 1'b0, idle_i = 1'b0, wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] count_o;
   logic        irq_o, dir_up_o;

   int total = 0, bad = 0;
   logic [15:0] m_cnt, m_per;
   logic        m_irq;
   logic [2:0]  m_ctrl;

   always #2 clk = ~clk;

   dirsel_timer dut_i (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic [15:0] p, input logic up);
      if (up) return (c == p) ? 16'd0 : c + 16'd1;
      return (c == 16'd0) ? p : c - 16'd1;
   endfunction

   function automatic logic eff_up();
      return m_ctrl[1] ? dir_pin_i : m_ctrl[0];
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
      case (a)
         2'd0: m_cnt = d;
         2'd1: m_per = d;
         2'd2: m_ctrl = d[2:0];
         default: m_irq = 1'b0;
      endcase
   endtask

   task automatic pulse_model();
      logic up;
      up = eff_up();
      ext_clk_i = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk);
      if (mode_i && !sleep_i && !(idle_i && m_ctrl[2])) begin
         m_cnt = next_cnt(m_cnt, m_per, up);
         if (m_cnt == m_per) m_irq = 1'b1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e));
      m_cnt = 0; m_per = 16'hFFFF; m_irq = 0; m_ctrl = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count", count_o, 16'd0);
      chk("R1 irq", {15'd0, irq_o}, 16'd0);
      chk("R1 dir", {15'd0, dir_up_o}, 16'd0);

      // R6 with reset period: down from zero loads all ones, R7 sets flag
      mode_i = 1'b1;
      pulse_model();
      chk("R6 down wrap reset period", count_o, 16'hFFFF);
      chk("R7 flag on match", {15'd0, irq_o}, {15'd0, m_irq});
      wr(2'd3, 16'd0);
      chk("R7 clear", {15'd0, irq_o}, 16'd0);

      // R8: count write on the same cycle as a step
      wr(2'd2, 16'd1); wr(2'd1, 16'd100); wr(2'd0, 16'd5);
      ext_clk_i = 1'b1;
      @(negedge clk); @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 16'd40;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R8 write beats step", count_o, 16'd40);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 count after", count_o, 16'd40);
      chk("R8 no flag", {15'd0, irq_o}, 16'd0);
      m_cnt = 16'd40;

      // R7: flag set on the same cycle as a clear
      wr(2'd0, 16'd99);
      ext_clk_i = 1'b1;
      @(negedge clk); @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 16'd0;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R7 set beats clear", {15'd0, irq_o}, 16'd1);
      chk("R5 reaches period", count_o, 16'd100);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk);
      m_cnt = 16'd100; m_irq = 1'b1;
      pulse_model();
      chk("R5 up wrap", count_o, 16'd0);
      wr(2'd3, 16'd0);

      // R2: falling edge alone gives no step
      ext_clk_i = 1'b1; repeat (3) @(negedge clk);
      m_cnt = next_cnt(m_cnt, m_per, 1'b1);
      chk("R2 rise step", count_o, m_cnt);
      ext_clk_i = 1'b0; repeat (4) @(negedge clk);
      chk("R2 fall no step", count_o, m_cnt);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op == 0) wr(2'd2, 16'($urandom_range(0, 7)));
         else if (op == 1) wr(2'd0, 16'($urandom_range(0, 8)));
         else if (op == 2) wr(2'd1, 16'($urandom_range(0, 7)));
         else if (op == 3) wr(2'd3, 16'd0);
         else begin
            mode_i    = ($urandom_range(0, 9) != 0);
            sleep_i   = ($urandom_range(0, 6) == 0);
            idle_i    = ($urandom_range(0, 2) == 0);
            dir_pin_i = 1'($urandom_range(0, 1));
            repeat (3) @(negedge clk);
            chk(m_ctrl[1] ? "R4 pin direction" : "R3 sw direction",
                {15'd0, dir_up_o}, {15'd0, eff_up()});
            pulse_model();
            chk(!mode_i ? "R9 mode gate" : sleep_i ? "R10 sleep gate" :
                idle_i ? "R11 idle gate" : "R5 R6 count step", count_o, m_cnt);
            chk("R7 flag", {15'd0, irq_o}, {15'd0, m_irq});
         end
         @(negedge clk);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule